// File: doc/BRIEF.md
# Two-Direction Successor Wake Table

This block works next to a set-associative branch target buffer whose entries sleep in a low-leakage state. It learns which buffer entry holds the branch that comes next after each resident branch. Each buffer entry has two learned links: one for the path the branch takes when taken, and one for the fall-through path. When the fetch side hits an entry, the block reads both links of that entry. It then pulses a wake line for each linked entry, so the power-mode controller can wake those entries before they are needed.

The links are learned at execute. A branch counts as qualifying when it resolved taken or already sits in the buffer. A location register records the set, the way and the direction of the last qualifying branch. When the next qualifying branch arrives, its location is written into one field of the previous branch's entry. The stored direction picks the field: taken or not-taken. A qualifying branch that is not yet present is being allocated, so its entry's old links are discarded.

Top module: `succ_wake_table`

## Requirements
- R1: After a synchronous reset, every wake line is low. No learned link is valid until it is written again.
- R2: An execute update qualifies only if upd_valid is high and either upd_taken or upd_present is high. Any other update leaves the location register and the table unchanged.
- R3: A qualifying update writes its own entry location into the entry held in the location register. The write goes to the taken field when the stored direction is 1, and to the not-taken field when it is 0.
- R4: The first qualifying update after reset writes no link; it only loads the location register.
- R5: A lookup hit presented in cycle k raises the wake lines in cycle k+3 for exactly one cycle. With no hit, all wake lines stay low.
- R6: When both fields of the looked-up entry are valid, both linked entries are woken together.
- R7: A field that is not valid raises no wake line.
- R8: A qualifying update with upd_present low clears both fields of its own entry. If a link is written into that same entry in the same cycle, the link write wins for its field.
- R9: Qualifying updates in back-to-back cycles chain correctly. Each one links to the update directly before it.
- R10: A table read sees the contents from before any update presented in the cycle after the lookup.
- R11: At most two wake lines are high in any cycle.
- R12: Entry index = set × WAYS + way. The way is the position of the single set bit in the one-hot way vector, bit i meaning way i. Wake line n belongs to entry n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_valid | input | 1 | Execute-stage branch update present |
| upd_set | input | SET_W | Buffer set of the updating branch (PC index bits) |
| upd_way_hit | input | WAYS | One-hot way of the updating branch's entry |
| upd_taken | input | 1 | Branch resolved taken |
| upd_present | input | 1 | Branch already occupied its buffer entry |
| lk_hit | input | 1 | Fetch-side buffer lookup hit |
| lk_set | input | SET_W | Set of the lookup hit |
| lk_way_hit | input | WAYS | One-hot way of the lookup hit |
| wake_o | output | SETS*WAYS | Registered pre-activation pulse, one line per buffer entry |

## Verification
The checker watches four rules on every cycle:
- wake lines are clear just after reset;
- no more than two lines are high at once;
- a wake only follows a lookup hit three cycles before;
- a non-qualifying update never disturbs the location register.

Only the bench scenarios can show the rest, by comparing each wake pulse against a reference table:
- which field a link lands in;
- the first-update case;
- clearing on allocation and the link-write priority;
- back-to-back chaining and read-before-write ordering.

A long random phase over four sets creates frequent self-links and collisions.

// File: rtl/swt_pkg.sv
package swt_pkg;
  typedef enum logic {
    DIR_NT = 1'b0,
    DIR_TK = 1'b1
  } dir_e;
endpackage

// File: rtl/swt_way_enc.sv
module swt_way_enc #(
  parameter int WAYS  = 4,
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  way_oh,
  output logic [WAY_W-1:0] way_bin
);
  always_comb begin
    way_bin = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (way_oh[i]) way_bin = way_bin | WAY_W'(i);
    end
  end
endmodule

// File: rtl/swt_link_store.sv
module swt_link_store
  import swt_pkg::*;
#(
  parameter int ENTRIES = 256,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  dir_e             wr_dir,
  input  logic [IDX_W-1:0] wr_loc,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_tk_v,
  output logic [IDX_W-1:0] rd_tk_loc,
  output logic             rd_nt_v,
  output logic [IDX_W-1:0] rd_nt_loc
);
  logic [IDX_W-1:0] mem_tk [ENTRIES];
  logic [IDX_W-1:0] mem_nt [ENTRIES];
  logic [ENTRIES-1:0] vld_tk, vld_nt;

  always_ff @(posedge clk) begin
    if (wr_en && wr_dir == DIR_TK) mem_tk[wr_idx] <= wr_loc;
    if (rd_en) rd_tk_loc <= mem_tk[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (wr_en && wr_dir == DIR_NT) mem_nt[wr_idx] <= wr_loc;
    if (rd_en) rd_nt_loc <= mem_nt[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_tk <= '0;
      vld_nt <= '0;
    end else begin
      if (clr_en) begin
        vld_tk[clr_idx] <= 1'b0;
        vld_nt[clr_idx] <= 1'b0;
      end
      if (wr_en) begin
        if (wr_dir == DIR_TK) vld_tk[wr_idx] <= 1'b1;
        else                  vld_nt[wr_idx] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_tk_v <= 1'b0;
      rd_nt_v <= 1'b0;
    end else if (rd_en) begin
      rd_tk_v <= vld_tk[rd_idx];
      rd_nt_v <= vld_nt[rd_idx];
    end else begin
      rd_tk_v <= 1'b0;
      rd_nt_v <= 1'b0;
    end
  end
endmodule

// File: rtl/swt_wake_dec.sv
module swt_wake_dec #(
  parameter int ENTRIES = 256,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tk_v,
  input  logic [IDX_W-1:0]   tk_loc,
  input  logic               nt_v,
  input  logic [IDX_W-1:0]   nt_loc,
  output logic [ENTRIES-1:0] wake
);
  logic [ENTRIES-1:0] wake_nxt;

  always_comb begin
    wake_nxt = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if ((tk_v && tk_loc == IDX_W'(e)) || (nt_v && nt_loc == IDX_W'(e)))
        wake_nxt[e] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) wake <= '0;
    else     wake <= wake_nxt;
  end
endmodule

// File: rtl/succ_wake_table.sv
module succ_wake_table
  import swt_pkg::*;
#(
  parameter int SETS    = 64,
  parameter int WAYS    = 4,
  parameter int SET_W   = $clog2(SETS),
  parameter int WAY_W   = $clog2(WAYS),
  parameter int IDX_W   = SET_W + WAY_W,
  parameter int ENTRIES = SETS * WAYS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               upd_valid,
  input  logic [SET_W-1:0]   upd_set,
  input  logic [WAYS-1:0]    upd_way_hit,
  input  logic               upd_taken,
  input  logic               upd_present,
  input  logic               lk_hit,
  input  logic [SET_W-1:0]   lk_set,
  input  logic [WAYS-1:0]    lk_way_hit,
  output logic [ENTRIES-1:0] wake_o
);
  logic [WAY_W-1:0] upd_way, lk_way;
  logic [IDX_W-1:0] upd_idx, lk_idx;
  logic             upd_qual;

  // Location register: last qualifying branch
  logic             lr_v;
  logic [IDX_W-1:0] lr_idx;
  dir_e             lr_dir;

  // Latched lookup row
  logic             lk_q_v;
  logic [IDX_W-1:0] lk_q_idx;

  logic             pa_tk_v, pa_nt_v;
  logic [IDX_W-1:0] pa_tk_loc, pa_nt_loc;

  swt_way_enc #(.WAYS(WAYS), .WAY_W(WAY_W)) upd_enc_i (
    .way_oh (upd_way_hit),
    .way_bin(upd_way)
  );

  swt_way_enc #(.WAYS(WAYS), .WAY_W(WAY_W)) lk_enc_i (
    .way_oh (lk_way_hit),
    .way_bin(lk_way)
  );

  assign upd_idx  = {upd_set, upd_way};
  assign lk_idx   = {lk_set, lk_way};
  assign upd_qual = upd_valid && (upd_taken || upd_present);

  always_ff @(posedge clk) begin
    if (rst) begin
      lr_v   <= 1'b0;
      lr_idx <= '0;
      lr_dir <= DIR_NT;
    end else if (upd_qual) begin
      lr_v   <= 1'b1;
      lr_idx <= upd_idx;
      lr_dir <= upd_taken ? DIR_TK : DIR_NT;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_q_v   <= 1'b0;
      lk_q_idx <= '0;
    end else begin
      lk_q_v <= lk_hit;
      if (lk_hit) lk_q_idx <= lk_idx;
    end
  end

  swt_link_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) store_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (upd_qual && lr_v),
    .wr_idx   (lr_idx),
    .wr_dir   (lr_dir),
    .wr_loc   (upd_idx),
    .clr_en   (upd_qual && !upd_present),
    .clr_idx  (upd_idx),
    .rd_en    (lk_q_v),
    .rd_idx   (lk_q_idx),
    .rd_tk_v  (pa_tk_v),
    .rd_tk_loc(pa_tk_loc),
    .rd_nt_v  (pa_nt_v),
    .rd_nt_loc(pa_nt_loc)
  );

  swt_wake_dec #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) dec_i (
    .clk   (clk),
    .rst   (rst),
    .tk_v  (pa_tk_v),
    .tk_loc(pa_tk_loc),
    .nt_v  (pa_nt_v),
    .nt_loc(pa_nt_loc),
    .wake  (wake_o)
  );
endmodule

// File: rtl/swt_checker.sv
module swt_checker #(
  parameter int ENTRIES = 256,
  parameter int IDX_W   = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               upd_valid,
  input logic               upd_taken,
  input logic               upd_present,
  input logic               lk_hit,
  input logic [ENTRIES-1:0] wake_o,
  input logic               lr_v,
  input logic [IDX_W-1:0]   lr_idx
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> wake_o == '0);

  // R11
  wake_pair_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(wake_o) <= 2);

  // R5
  wake_source_chk: assert property (@(posedge clk) disable iff (rst)
    (wake_o != '0) |-> $past(lk_hit, 3));

  // R2
  skip_update_chk: assert property (@(posedge clk) disable iff (rst)
    (!upd_valid || (!upd_taken && !upd_present)) |=> ($stable(lr_v) && $stable(lr_idx)));
endmodule

bind succ_wake_table swt_checker #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .upd_valid  (upd_valid),
  .upd_taken  (upd_taken),
  .upd_present(upd_present),
  .lk_hit     (lk_hit),
  .wake_o     (wake_o),
  .lr_v       (lr_v),
  .lr_idx     (lr_idx)
);

// File: tb/succ_wake_table_tb_top.sv
module succ_wake_table_tb_top;
  localparam int SETS = 64;
  localparam int WAYS = 4;
  localparam int ENT  = SETS * WAYS;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           upd_valid = 1'b0;
  logic [5:0]     upd_set = '0;
  logic [3:0]     upd_way_hit = '0;
  logic           upd_taken = 1'b0;
  logic           upd_present = 1'b0;
  logic           lk_hit = 1'b0;
  logic [5:0]     lk_set = '0;
  logic [3:0]     lk_way_hit = '0;
  logic [ENT-1:0] wake_o;

  always #5 clk = ~clk;

  succ_wake_table #(.SETS(SETS), .WAYS(WAYS)) dut_i (
    .clk(clk), .rst(rst),
    .upd_valid(upd_valid), .upd_set(upd_set), .upd_way_hit(upd_way_hit),
    .upd_taken(upd_taken), .upd_present(upd_present),
    .lk_hit(lk_hit), .lk_set(lk_set), .lk_way_hit(lk_way_hit),
    .wake_o(wake_o)
  );

  int  total = 0;
  int  fails = 0;
  int  cyc = 0;
  bit  run = 1'b0;
  bit  done = 1'b0;

  // reference table, written from the requirements
  bit m_tk_v [ENT];
  int m_tk_l [ENT];
  bit m_nt_v [ENT];
  int m_nt_l [ENT];
  bit m_lr_v = 1'b0;
  int m_lr_i = 0;
  bit m_lr_d = 1'b0;

  int             q_cyc [$];
  logic [ENT-1:0] q_vec [$];
  string          q_tag [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, logic [ENT-1:0] act, logic [ENT-1:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle %0d actual=%h expected=%h", req, cyc, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  function automatic logic [ENT-1:0] expect_wake(int idx);
    logic [ENT-1:0] v = '0;
    if (m_tk_v[idx]) v[m_tk_l[idx]] = 1'b1;
    if (m_nt_v[idx]) v[m_nt_l[idx]] = 1'b1;
    return v;
  endfunction

  // Driver: one cycle of stimulus; the model applies the update first (R10 ordering)
  task automatic step(bit uv, int us, int uw, bit ut, bit up,
                      bit lv, int ls, int lw, string tag);
    int cur;
    @(negedge clk);
    upd_valid   = uv;
    upd_set     = us[5:0];
    upd_way_hit = 4'(1 << uw);
    upd_taken   = ut;
    upd_present = up;
    lk_hit      = lv;
    lk_set      = ls[5:0];
    lk_way_hit  = 4'(1 << lw);
    if (uv && (ut || up)) begin
      cur = us * WAYS + uw;
      if (!up) begin
        m_tk_v[cur] = 1'b0;
        m_nt_v[cur] = 1'b0;
      end
      if (m_lr_v) begin
        if (m_lr_d) begin m_tk_v[m_lr_i] = 1'b1; m_tk_l[m_lr_i] = cur; end
        else        begin m_nt_v[m_lr_i] = 1'b1; m_nt_l[m_lr_i] = cur; end
      end
      m_lr_v = 1'b1;
      m_lr_i = cur;
      m_lr_d = ut;
    end
    if (lv) begin
      q_cyc.push_back(cyc + 3);
      q_vec.push_back(expect_wake(ls * WAYS + lw));
      q_tag.push_back(tag);
    end
  endtask

  task automatic upd(int s, int w, bit t, bit p, string tag);
    step(1'b1, s, w, t, p, 1'b0, 0, 0, tag);
  endtask

  task automatic look(int s, int w, string tag);
    step(1'b0, 0, 0, 1'b0, 1'b0, 1'b1, s, w, tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 0, 0, 1'b0, 1'b0, 1'b0, 0, 0, "R5");
  endtask

  // Monitor: pops scoreboard items as they fall due; otherwise expects silence
  always @(negedge clk) begin
    if (run) begin
      logic [ENT-1:0] exp;
      string tag;
      exp = '0;
      tag = "R5";
      if (q_cyc.size() > 0 && q_cyc[0] == cyc) begin
        void'(q_cyc.pop_front());
        exp = q_vec.pop_front();
        tag = q_tag.pop_front();
      end
      check(wake_o === exp, tag, wake_o, exp);
      check($countones(wake_o) <= 2, "R11", wake_o, exp);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL R5 watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < ENT; i++) begin
      m_tk_v[i] = 1'b0; m_nt_v[i] = 1'b0; m_tk_l[i] = 0; m_nt_l[i] = 0;
    end
    repeat (3) @(negedge clk);
    check(wake_o === '0, "R1", wake_o, '0);
    rst = 1'b0;
    run = 1'b1;
    // R1, R7: nothing learned yet
    look(1, 0, "R1");
    look(3, 2, "R7");
    idle(3);
    // R4: first qualifying update writes nothing
    upd(1, 0, 1'b1, 1'b0, "R4");        // A, taken, allocated
    look(1, 0, "R4");
    idle(3);
    // R2: non-qualifying update ignored, R3 taken field
    upd(2, 1, 1'b0, 1'b0, "R2");        // B ignored
    upd(3, 2, 1'b0, 1'b1, "R3");        // C -> A.taken
    look(1, 0, "R2");                   // only C wakes, not B
    upd(4, 3, 1'b1, 1'b1, "R3");        // D -> C.not-taken
    look(3, 2, "R3");
    idle(3);
    // R9 back-to-back, R6 both fields
    upd(1, 0, 1'b0, 1'b1, "R9");        // A -> D.taken
    upd(5, 1, 1'b1, 1'b1, "R9");        // E -> A.not-taken
    look(1, 0, "R6");
    look(4, 3, "R9");
    idle(3);
    // R8 allocation clears own entry
    upd(1, 0, 1'b1, 1'b0, "R8");        // A realloc -> E.taken, A cleared
    look(1, 0, "R8");
    look(5, 1, "R8");
    idle(3);
    // R8 link write to the entry being cleared wins for its field
    upd(1, 0, 1'b1, 1'b1, "R8");        // A -> A.taken
    upd(1, 0, 1'b1, 1'b0, "R8");        // clear A, A.taken <- A
    look(1, 0, "R8");
    idle(3);
    // R10: write in the cycle after a lookup is not seen by it
    upd(5, 1, 1'b0, 1'b1, "R10");       // E -> A.taken, lr = E not-taken
    look(5, 1, "R10");
    upd(6, 2, 1'b1, 1'b1, "R10");       // G -> E.not-taken
    idle(1);
    look(5, 1, "R10");
    idle(3);
    // R12 indexing across set/way corners, R3 random chaining with collisions
    upd(63, 3, 1'b1, 1'b1, "R12");
    upd(0, 0, 1'b1, 1'b1, "R12");
    look(63, 3, "R12");
    idle(3);
    for (int k = 0; k < 400; k++) begin
      step(1'($urandom_range(0, 1)), $urandom_range(0, 3), $urandom_range(0, 3),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), $urandom_range(0, 3), $urandom_range(0, 3), "R3");
    end
    idle(6);
    check(q_cyc.size() == 0, "R5", ENT'(q_cyc.size()), '0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule